// File: doc/BRIEF.md
# Fetch Address Sequencer

This block owns the fetch address of a single-issue 32-bit core whose instructions are one word wide. Each cycle it looks at the instruction word that sits at the current address and works out where fetch goes next. It decodes the operation and function fields to pick one of four targets: the next word in order, a displacement relative to the following instruction, a region-local absolute jump, or an address taken from a register. The comparison result for conditional branches comes from outside, and so does the register operand for indirect jumps.

The address register moves only when the advance input is high. When advance is low it holds its value. For call instructions the block supplies the return address and a strobe that marks the write into the link register.

Top module: `pc_sequencer`

## Requirements
- R1: In the cycle after reset is sampled high, `pc_o` equals parameter RESET_ADDR with its two low bits forced to zero.
- R2: Under advance, an instruction that changes no flow moves `pc_o` to `pc_o + 4` on the next edge. Wraparound past the top of the address space is modulo 2^32.
- R3: Operation field [31:26] = 4 with `operands_equal_i` = 1 loads `pc_o + 4 + (sign_extend(instr[15:0]) << 2)`. With `operands_equal_i` = 0 it loads `pc_o + 4`.
- R4: Operation field 5 with `operands_equal_i` = 0 loads the same displaced target as R3. With `operands_equal_i` = 1 it loads `pc_o + 4`.
- R5: The displacement is signed. 0x8000 reaches back 2^15 instructions and 0x7FFF reaches forward 2^15-1 instructions, both counted from `pc_o + 4`.
- R6: Operation field 2 or 3 loads `{pc_plus4[31:28], instr[25:0], 2'b00}`. The top four bits come from `pc_o + 4`.
- R7: Operation field 0 with function field [5:0] = 8 loads `jump_reg_i` with bits [1:0] cleared. Operation field 0 with any other function value advances by 4.
- R8: When `advance_i` is low, `pc_o` keeps its value whatever the instruction is.
- R9: `link_we_o` is high exactly when the operation field is 3 and `advance_i` is high. In that case `link_addr_o` equals `pc_o + 4` and `link_reg_o` equals 31.
- R10: Bits [1:0] of `pc_o` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| advance_i | input | 1 | Update the address this cycle |
| instr_i | input | 32 | Instruction word at the current address |
| operands_equal_i | input | 1 | Register equality result for conditional branches |
| jump_reg_i | input | 32 | Register value used by an indirect jump |
| pc_o | output | 32 | Current fetch address |
| link_addr_o | output | 32 | Return address for a call |
| link_reg_o | output | 5 | Register index that receives the return address |
| link_we_o | output | 1 | Link write strobe |

## Verification
The address register is the only state in the block. A decision made from the inputs in one cycle therefore appears on `pc_o` one edge later, while the link outputs are combinational and are valid in the same cycle as the instruction. The bench drives its inputs on the falling edge. It checks the link outputs before the rising edge. After each rising edge it compares `pc_o` with a behavioural model that the same edge has moved forward.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
    localparam int XLEN     = 32;
    localparam int OPW      = 6;
    localparam int FNW      = 6;
    localparam int IMMW     = 16;
    localparam int JIDXW    = 26;
    localparam int REGIDXW  = 5;
    localparam int INSTR_BYTES = 4;
    localparam int ALIGNW   = 2;

    localparam logic [OPW-1:0] OP_SPECIAL = 6'd0;
    localparam logic [OPW-1:0] OP_JUMP    = 6'd2;
    localparam logic [OPW-1:0] OP_CALL    = 6'd3;
    localparam logic [OPW-1:0] OP_BR_EQ   = 6'd4;
    localparam logic [OPW-1:0] OP_BR_NE   = 6'd5;
    localparam logic [FNW-1:0] FN_JREG    = 6'd8;
    localparam logic [REGIDXW-1:0] LINK_REG = 5'd31;

    typedef enum logic [1:0] {
        SRC_SEQ,
        SRC_REL,
        SRC_ABS,
        SRC_REG
    } next_src_e;

    typedef struct packed {
        next_src_e  src;
        logic       is_cond;
        logic       want_equal;
        logic       is_call;
    } flow_dec_t;

    function automatic logic [XLEN-1:0] align_word(input logic [XLEN-1:0] a);
        return {a[XLEN-1:ALIGNW], {ALIGNW{1'b0}}};
    endfunction
endpackage

// File: rtl/pc_flow_decode.sv
module pc_flow_decode
    import pc_seq_pkg::*;
(
    input  logic [XLEN-1:0] instr_i,
    output flow_dec_t       dec_o
);
    logic [OPW-1:0] op;
    logic [FNW-1:0] fn;

    assign op = instr_i[XLEN-1 -: OPW];
    assign fn = instr_i[FNW-1:0];

    always_comb begin
        dec_o = '{src: SRC_SEQ, is_cond: 1'b0, want_equal: 1'b0, is_call: 1'b0};
        unique case (op)
            OP_BR_EQ: begin
                dec_o.src        = SRC_REL;
                dec_o.is_cond    = 1'b1;
                dec_o.want_equal = 1'b1;
            end
            OP_BR_NE: begin
                dec_o.src     = SRC_REL;
                dec_o.is_cond = 1'b1;
            end
            OP_JUMP:  dec_o.src = SRC_ABS;
            OP_CALL: begin
                dec_o.src     = SRC_ABS;
                dec_o.is_call = 1'b1;
            end
            OP_SPECIAL: if (fn == FN_JREG) dec_o.src = SRC_REG;
            default: ;
        endcase
    end
endmodule

// File: rtl/pc_target_gen.sv
module pc_target_gen
    import pc_seq_pkg::*;
(
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] instr_i,
    input  logic [XLEN-1:0] jump_reg_i,
    output logic [XLEN-1:0] seq_o,
    output logic [XLEN-1:0] rel_o,
    output logic [XLEN-1:0] abs_o,
    output logic [XLEN-1:0] reg_o
);
    localparam int HIW = XLEN - JIDXW - ALIGNW;
    logic [XLEN-1:0] disp;

    assign seq_o = pc_i + XLEN'(INSTR_BYTES);
    assign disp  = {{(XLEN-IMMW-ALIGNW){instr_i[IMMW-1]}}, instr_i[IMMW-1:0], {ALIGNW{1'b0}}};
    assign rel_o = seq_o + disp;
    assign abs_o = {seq_o[XLEN-1 -: HIW], instr_i[JIDXW-1:0], {ALIGNW{1'b0}}};
    assign reg_o = align_word(jump_reg_i);
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter logic [31:0] RESET_ADDR = 32'h0040_0000
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        advance_i,
    input  logic [31:0] instr_i,
    input  logic        operands_equal_i,
    input  logic [31:0] jump_reg_i,
    output logic [31:0] pc_o,
    output logic [31:0] link_addr_o,
    output logic [4:0]  link_reg_o,
    output logic        link_we_o
);
    localparam logic [XLEN-1:0] RST_ALIGNED = {RESET_ADDR[XLEN-1:ALIGNW], {ALIGNW{1'b0}}};

    flow_dec_t       dec;
    logic [XLEN-1:0] t_seq, t_rel, t_abs, t_reg, next_pc;
    logic [XLEN-1:0] pc_q;
    logic            take_rel;

    pc_flow_decode u_dec (.instr_i(instr_i), .dec_o(dec));

    pc_target_gen u_tgt (
        .pc_i(pc_q), .instr_i(instr_i), .jump_reg_i(jump_reg_i),
        .seq_o(t_seq), .rel_o(t_rel), .abs_o(t_abs), .reg_o(t_reg)
    );

    assign take_rel = dec.is_cond && (operands_equal_i == dec.want_equal);

    always_comb begin
        unique case (dec.src)
            SRC_REL: next_pc = take_rel ? t_rel : t_seq;
            SRC_ABS: next_pc = t_abs;
            SRC_REG: next_pc = t_reg;
            default: next_pc = t_seq;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)          pc_q <= RST_ALIGNED;
        else if (advance_i) pc_q <= next_pc;
    end

    assign pc_o        = pc_q;
    assign link_addr_o = t_seq;
    assign link_reg_o  = LINK_REG;
    assign link_we_o   = dec.is_call && advance_i;

    p_reset_value_r1: assert property (@(posedge clk_i) rst_i |=> pc_o == RST_ALIGNED);
    p_aligned_r10: assert property (@(posedge clk_i) disable iff (rst_i) pc_o[1:0] == 2'b00);
    p_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !advance_i |=> $stable(pc_o));
    p_seq_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (advance_i && dec.src == SRC_SEQ) |=> pc_o == $past(pc_o) + 32'd4);
    p_jreg_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (advance_i && instr_i[31:26] == 6'd0 && instr_i[5:0] == 6'd8)
        |=> pc_o == {$past(jump_reg_i[31:2]), 2'b00});
    p_link_strobe_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        link_we_o |-> (instr_i[31:26] == 6'd3 && link_addr_o == pc_o + 32'd4));
    p_jump_region_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (advance_i && instr_i[31:27] == 5'b00001)
        |=> pc_o == {$past(link_addr_o[31:28]), $past(instr_i[25:0]), 2'b00});
endmodule

// File: tb/pc_sequencer_bench.sv
`timescale 1ns/1ps
module pc_sequencer_bench;
    localparam logic [31:0] RST = 32'h0040_0003;

    logic        clk = 1'b0;
    logic        rst, adv, eq;
    logic [31:0] instr, jreg;
    logic [31:0] pc, laddr;
    logic [4:0]  lreg;
    logic        lwe;
    int checks = 0, fails = 0;
    logic [31:0] model_pc;

    always #4 clk = ~clk;

    pc_sequencer #(.RESET_ADDR(RST)) u_pc_sequencer (
        .clk_i(clk), .rst_i(rst), .advance_i(adv), .instr_i(instr),
        .operands_equal_i(eq), .jump_reg_i(jreg), .pc_o(pc),
        .link_addr_o(laddr), .link_reg_o(lreg), .link_we_o(lwe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_next(input logic [31:0] p, input logic [31:0] i,
                                               input logic e, input logic [31:0] r);
        logic [31:0] s;
        int op;
        s  = p + 4;
        op = int'(i[31:26]);
        if (op == 4 && e)                           return s + {{14{i[15]}}, i[15:0], 2'b00};
        if (op == 5 && !e)                          return s + {{14{i[15]}}, i[15:0], 2'b00};
        if (op == 2 || op == 3)                     return {s[31:28], i[25:0], 2'b00};
        if (op == 0 && i[5:0] == 6'd8)              return {r[31:2], 2'b00};
        return s;
    endfunction

    // Apply one instruction on the falling edge, check link outputs, then pc after the rising edge.
    task automatic step(input string req, input logic a, input logic [31:0] i,
                        input logic e, input logic [31:0] r);
        @(negedge clk);
        adv = a; instr = i; eq = e; jreg = r;
        #1;
        chk("R9 strobe", {31'd0, lwe}, {31'd0, a && i[31:26] == 6'd3});
        if (i[31:26] == 6'd3) begin
            chk("R9 link addr", laddr, model_pc + 4);
            chk("R9 link reg", {27'd0, lreg}, 32'd31);
        end
        if (a) model_pc = model_next(model_pc, i, e, r);
        @(posedge clk); #1;
        chk(req, pc, model_pc);
        chk("R10 align", {30'd0, pc[1:0]}, 32'd0);
    endtask

    initial begin
        #150000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1; adv = 0; instr = 0; eq = 0; jreg = 0;
        repeat (2) @(posedge clk);
        #1;
        model_pc = 32'h0040_0000;
        chk("R1 reset", pc, model_pc);
        @(negedge clk); rst = 0;
        step("R2 seq", 1, 32'h0000_0020, 0, 0);               // add-like funct
        step("R2 seq2", 1, 32'h8C00_0000, 0, 0);              // other op
        step("R3 beq taken", 1, {6'd4, 10'd0, 16'h0010}, 1, 0);
        step("R3 beq not", 1, {6'd4, 10'd0, 16'h0010}, 0, 0);
        step("R4 bne taken", 1, {6'd5, 10'd0, 16'hFFFE}, 0, 0);
        step("R4 bne not", 1, {6'd5, 10'd0, 16'h0040}, 1, 0);
        step("R5 max back", 1, {6'd4, 10'd0, 16'h8000}, 1, 0);
        step("R5 max fwd", 1, {6'd4, 10'd0, 16'h7FFF}, 1, 0);
        step("R6 jump", 1, {6'd2, 26'h3AB_CDEF}, 0, 0);
        step("R6 call", 1, {6'd3, 26'h012_3456}, 0, 0);
        step("R8 hold call", 0, {6'd3, 26'h3FF_FFFF}, 0, 0);
        step("R8 hold jreg", 0, 32'h0000_0008, 0, 32'h1234_5678);
        step("R7 jreg", 1, 32'h0120_0008, 0, 32'hEFFF_FFFF);
        step("R7 other funct", 1, 32'h0120_0009, 0, 32'h0000_1000);
        step("R6 region top", 1, {6'd2, 26'h3FF_FFFF}, 0, 0);
        step("R2 wrap", 1, 32'h0000_0008, 0, 32'hFFFF_FFFC);
        step("R2 wrap seq", 1, 32'h0000_0000, 0, 0);
        step("R6 call after wrap", 1, {6'd3, 26'h000_0004}, 0, 0);
        @(negedge clk); rst = 1; @(posedge clk); #1;
        model_pc = 32'h0040_0000;
        chk("R1 re-reset", pc, model_pc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule